// File: doc/BRIEF.md
# Program-Verify Retry Sequencer

This block controls the programming or erasing of one flash location by a loop of pulses and verify reads. When it accepts a start request, it records whether the operation is an erase or a write. It also records the value the location must hold afterwards. It then requests one programming pulse from the array and waits for the acknowledge. Next it asks for a read-back of the location. The value returned is compared with the expected value.

A matching read ends the operation successfully. On a mismatch the block applies a further pulse and verifies again. It stops once a parameterised maximum number of pulses has been applied. If the location still disagrees after that last pulse, the block raises a sticky flash-error flag. Every operation, whether it passes or fails, ends with a single-cycle done strobe. Erase and write use exactly the same loop. The only difference is the expected value: for an erase it is all ones.

Top module: `pv_retry_seq`

## Requirements
- R1: After reset, pulse_req_o, rd_req_o, done_o, err_o and busy_o are all 0.
- R2: A start_i seen while idle begins an operation, and its first action is a pulse request. A start_i seen while busy_o is 1 is ignored: it causes no extra pulse and no extra done.
- R3: pulse_req_o stays high until pulse_ack_i is sampled. Each acknowledged pulse is followed by exactly one verify read (rd_req_o held until rd_valid_i). pulse_req_o and rd_req_o are never high together.
- R4: When the verify read equals the expected value, the operation ends with done_o and no further pulse, and err_o is not set by it.
- R5: When the verify read differs and fewer than MAX_PULSES pulses have been applied, another pulse is requested.
- R6: When the verify read still differs after MAX_PULSES pulses, the operation ends with done_o and err_o becomes 1.
- R7: For an erase (op_erase_i = 1) the expected value is all ones, and wdata_i is ignored. For a write (op_erase_i = 0) the expected value is wdata_i as sampled with start_i.
- R8: done_o is high for exactly one cycle at the end of every operation.
- R9: err_o stays 1 across later operations until clr_err_i is high for a cycle. If a failing end and a clear arrive in the same cycle, err_o is set.
- R10: The pulse count restarts at zero on every accepted start, so each operation may use up to MAX_PULSES pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = write |
| wdata_i | input | DATA_W | Value to be written (write operations) |
| clr_err_i | input | 1 | Clear the sticky error flag |
| pulse_req_o | output | 1 | Programming pulse request to the array |
| pulse_ack_i | input | 1 | Array has applied the pulse |
| rd_req_o | output | 1 | Verify read request |
| rd_valid_i | input | 1 | rd_data_i is valid |
| rd_data_i | input | DATA_W | Read-back value of the location |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle end-of-operation strobe |
| err_o | output | 1 | Sticky flash-error flag |

## Verification
A model of the array decides how many pulses a location needs before it reads back correctly. It returns a corrupted word on every read before that point. The number needed is drawn at random, from one up to two more than the limit. This tells apart early pass, pass on exactly the last allowed pulse, and failure. Erases are driven with a random wdata_i, so a design that compared against the write data instead of all ones would fail to match. Directed cases cover a start during a busy operation, the error flag persisting through a later passing operation, and a clear. A fail followed by an operation needing the full pulse budget shows whether the counter restarts. Handshake delays are randomised on both the pulse and the read side.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_READ  = 2'd2,
    ST_CHECK = 2'd3
  } pv_state_e;
endpackage

// File: rtl/pv_pulse_ctr.sv
module pv_pulse_ctr #(
  parameter int MAX_PULSES = 4,
  localparam int CNT_W = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PULSES);

  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i && cnt_o != LIMIT) cnt_o <= cnt_o + 1'b1;
  end

  assign at_max_o = (cnt_o == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= LIMIT);  // R5
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));  // R10
endmodule

// File: rtl/pv_verify_cmp.sv
module pv_verify_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              match_o
);
  logic [DATA_W-1:0] expect_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_q <= '0;
      match_o  <= 1'b0;
    end else begin
      if (load_i) begin
        expect_q <= erase_i ? {DATA_W{1'b1}} : wdata_i;
        match_o  <= 1'b0;
      end else if (sample_i) begin
        match_o <= (rd_data_i == expect_q);
      end
    end
  end

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (rst)
    (load_i && erase_i) |=> (expect_q == {DATA_W{1'b1}}));  // R7
endmodule

// File: rtl/pv_err_flag.sv
module pv_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst)        err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
    else if (clr_i) err_o <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_i) |=> err_o);  // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !err_o);  // R9
endmodule

// File: rtl/pv_retry_seq.sv
module pv_retry_seq #(
  parameter int DATA_W     = 32,
  parameter int MAX_PULSES = 4,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_err_i,
  output logic              pulse_req_o,
  input  logic              pulse_ack_i,
  output logic              rd_req_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  import pv_pkg::*;

  pv_state_e        state_q;
  logic             accept;
  logic             pulse_done;
  logic             read_done;
  logic             match;
  logic             at_max;
  logic             fail_end;
  logic [CNT_W-1:0] pulse_cnt;

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign pulse_done = (state_q == ST_PULSE) && pulse_ack_i;
  assign read_done  = (state_q == ST_READ) && rd_valid_i;
  assign fail_end   = (state_q == ST_CHECK) && !match && at_max;

  pv_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_ctr (
    .clk(clk), .rst(rst), .clr_i(accept), .inc_i(pulse_done),
    .cnt_o(pulse_cnt), .at_max_o(at_max)
  );

  pv_verify_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .load_i(accept), .erase_i(op_erase_i),
    .wdata_i(wdata_i), .sample_i(read_done), .rd_data_i(rd_data_i),
    .match_o(match)
  );

  pv_err_flag u_err (
    .clk(clk), .rst(rst), .set_i(fail_end), .clr_i(clr_err_i), .err_o(err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pulse_req_o <= 1'b0;
      rd_req_o    <= 1'b0;
      done_o      <= 1'b0;
      busy_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q     <= ST_PULSE;
          pulse_req_o <= 1'b1;
          busy_o      <= 1'b1;
        end
        ST_PULSE: if (pulse_ack_i) begin
          state_q     <= ST_READ;
          pulse_req_o <= 1'b0;
          rd_req_o    <= 1'b1;
        end
        ST_READ: if (rd_valid_i) begin
          state_q  <= ST_CHECK;
          rd_req_o <= 1'b0;
        end
        ST_CHECK: if (match || at_max) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          busy_o  <= 1'b0;
        end else begin
          state_q     <= ST_PULSE;
          pulse_req_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pulse_req_o && rd_req_o));  // R3
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pulse_req_o && !pulse_ack_i) |=> pulse_req_o);  // R3
  AST_VERIFY_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
    (pulse_req_o && pulse_ack_i) |=> rd_req_o);  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> pulse_req_o);  // R2
  AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
    fail_end |=> (err_o && done_o));  // R6
endmodule

// File: tb/pv_retry_seq_tb_top.sv
module pv_retry_seq_tb_top;
  localparam int DW   = 32;
  localparam int MAXP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, op_erase_i = 1'b0, clr_err_i = 1'b0;
  logic [DW-1:0] wdata_i = '0, rd_data_i = '0;
  logic          pulse_ack_i = 1'b0, rd_valid_i = 1'b0;
  logic          pulse_req_o, rd_req_o, busy_o, done_o, err_o;

  int n_chk = 0, n_bad = 0;
  bit err_model = 1'b0;

  always #5 clk = ~clk;

  pv_retry_seq #(.DATA_W(DW), .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_erase_i(op_erase_i),
    .wdata_i(wdata_i), .clr_err_i(clr_err_i), .pulse_req_o(pulse_req_o),
    .pulse_ack_i(pulse_ack_i), .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int need);
    return (need < MAXP) ? need : MAXP;
  endfunction

  task automatic run_op(input bit erase, input logic [DW-1:0] data, input int need,
                        input bit poke_busy);
    logic [DW-1:0] golden;
    int pulses = 0, reads = 0, guard = 0;
    golden = erase ? {DW{1'b1}} : data;
    @(negedge clk);
    start_i = 1'b1; op_erase_i = erase; wdata_i = data;
    @(negedge clk);
    start_i = 1'b0; wdata_i = $urandom;
    check(pulse_req_o == 1'b1, "R2 first action pulse", pulse_req_o, 1);
    forever begin
      if (done_o || guard > 2000) break;
      guard++;
      if (pulse_req_o) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        pulse_ack_i = 1'b1;
        @(negedge clk);
        pulse_ack_i = 1'b0;
        pulses++;
      end else if (rd_req_o) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rd_valid_i = 1'b1;
        rd_data_i  = (pulses >= need) ? golden : golden ^ (32'h1 << $urandom_range(0, DW-1));
        if (poke_busy) start_i = 1'b1;
        @(negedge clk);
        rd_valid_i = 1'b0;
        start_i    = 1'b0;
        reads++;
      end
      @(negedge clk);
    end
    if (need > MAXP) err_model = 1'b1;
    check(done_o == 1'b1, "R8 done reached", done_o, 1);
    check(pulses == exp_pulses(need), "R4/R5/R6 pulse count", pulses, exp_pulses(need));
    check(reads == pulses, "R3 one verify per pulse", reads, pulses);
    check(err_o == err_model, "R6/R9 error flag", err_o, err_model);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    check(busy_o == 1'b0 && pulse_req_o == 1'b0, "R2 idle after op (no restart)", busy_o, 0);
  endtask

  task automatic clear_err();
    @(negedge clk);
    clr_err_i = 1'b1;
    @(negedge clk);
    clr_err_i = 1'b0;
    err_model = 1'b0;
    check(err_o == 1'b0, "R9 clear", err_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({pulse_req_o, rd_req_o, done_o, err_o, busy_o} == 5'b0, "R1 reset state",
          {pulse_req_o, rd_req_o, done_o, err_o, busy_o}, 0);
    // R4 pass on first pulse, write
    run_op(1'b0, 32'hA5A5_0F0F, 1, 1'b0);
    // R7 erase, wdata random and must be ignored
    run_op(1'b1, 32'h0000_0000, 2, 1'b0);
    // R5 pass on exactly the last allowed pulse
    run_op(1'b0, 32'h1234_5678, MAXP, 1'b0);
    // R6 failure, then R9 sticky across a passing op
    run_op(1'b1, 32'hFFFF_0000, MAXP + 1, 1'b0);
    run_op(1'b0, 32'h0BAD_F00D, 1, 1'b0);
    clear_err();
    // R10 fail then full budget again
    run_op(1'b0, 32'h5555_AAAA, MAXP + 2, 1'b0);
    run_op(1'b0, 32'h3C3C_C3C3, MAXP, 1'b0);
    clear_err();
    // R2 start while busy ignored
    run_op(1'b0, 32'h7777_1111, 3, 1'b1);
    for (int i = 0; i < 40; i++) begin
      run_op(1'($urandom_range(0, 1)), $urandom, $urandom_range(1, MAXP + 2),
             1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) clear_err();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule